// File: doc/BRIEF.md
# Indirect CSR access controller

This block is the register front end of an Ethernet controller. The host reaches it through a small window of 16-bit I/O ports. An index port selects the number of an internal register. A data port then reads or writes the register that the index names. A third port resets the controller when it is read. A fourth port reaches a separate bus-configuration bank through the same index.

Inside the block there is one combined command/status word. It mixes command bits with sticky event flags that are cleared by writing a one to them. The block also holds the two halves of the 32-bit init-block address, a feature word, a read-only 32-bit chip identifier and a media configuration word. It drives one-cycle init, start, stop, transmit-demand and controller-reset strobes to the rest of the controller. It takes init-complete, transmit and receive event pulses back from it.

Reads are answered one clock after the request, together with a valid pulse. Writes take effect at the clock edge that samples them.

Top module: `ind_csr_ctrl`

## Requirements
- R1: After reset, the index reads 0, register 0 reads 0x0004, register 4 and bus-configuration word 2 read 0, and every strobe output is low.
- R2: A write to the index port (offset 0x12) stores the low IDX_W bits of the data. A read of the index port returns that number, zero-extended; writing 88 reads back 88.
- R3: Registers 88 and 89 read the low and high halves of the 32-bit identifier {4'h0, PART_ID, 12'h003}. With the default PART_ID of 0x5A3C they read 0xC003 and 0x05A3. Writes to them are ignored.
- R4: Registers 1 and 2 (data port, offset 0x10) are read/write and hold the low and high halves of init_addr. Writing 1 to bit 0 (init) of register 0 does three things: it pulses init_go for one cycle after the write, it sets bit 0, and it clears bit 2 (stop).
- R5: An init_loaded pulse sets bit 8 (init done) of register 0, visible from the cycle after the pulse.
- R6: Writing 1 to bit 1 (start) of register 0 sets bit 1, clears bit 2 and pulses start_go for one cycle. Writing 0 to any command bit has no effect.
- R7: Writing 1 to bit 3 (transmit demand) of register 0 pulses tx_demand for exactly one cycle. Bit 3 always reads 0.
- R8: tx_event sets bit 9 and rx_event sets bit 10. Writing 1 to bit 8, 9 or 10 clears that bit, so 0x0500 clears bits 10 and 8. An event in the same cycle as its clear leaves the bit set.
- R9: Writing 1 to bit 2 (stop) of register 0 takes priority over init, start and transmit demand in the same word. It sets bit 2, clears bits 0 and 1, and pulses only stop_go. While bit 2 is set, event inputs are ignored.
- R10: Register 4 is a 16-bit read/write feature word, driven on feature_word.
- R11: The bus-configuration port (offset 0x16) with index 2 reads and writes a word driven on bus_cfg_word, and media_autosel is its bit 1. Any other index reads 0 there. This word is separate from data-port register 2.
- R12: A read of the reset port (offset 0x14) returns 0 and pulses ctl_rst for one cycle. It also returns the index and every register to its reset value.
- R13: Each read of offsets 0x10, 0x12, 0x14 or 0x16 gives one bus_rvalid pulse one cycle later, with bus_rdata equal to the value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Host read request for one cycle |
| bus_wr | input | 1 | Host write request for one cycle |
| bus_offs | input | 5 | Port offset inside the I/O window |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read answer pulse, one cycle after bus_rd |
| ctl_rst | output | 1 | Controller reset strobe |
| init_go | output | 1 | Init command strobe |
| init_addr | output | 32 | Init-block address presented to the init loader |
| start_go | output | 1 | Start command strobe |
| stop_go | output | 1 | Stop command strobe |
| tx_demand | output | 1 | Transmit demand strobe |
| init_loaded | input | 1 | Init loader completion pulse |
| tx_event | input | 1 | Transmit completion event pulse |
| rx_event | input | 1 | Receive event pulse |
| feature_word | output | 16 | Contents of register 4 |
| bus_cfg_word | output | 16 | Bus-configuration word 2 |
| media_autosel | output | 1 | Media auto-select enable |

## Verification
Each command strobe, and each register change caused by a write, becomes visible in the cycle after the clock edge that samples the write. Event flags appear one cycle after their input pulse. Read data arrives with bus_rvalid one cycle after the request. The bench drives every input on falling edges and samples strobes and levels on the falling edge right after the capturing rising edge, so every result is read in the cycle it is due. Expected read words go into a queue when a read is issued, and a monitor pops and compares one word on each bus_rvalid pulse, so a missing, extra or late answer shows up as a mismatch.

// File: rtl/ics_pkg.sv
package ics_pkg;

    localparam int WORD_W  = 16;
    localparam int OFFS_W  = 5;
    localparam int NUM_EVT = 3;

    // Port offsets inside the I/O window
    localparam logic [OFFS_W-1:0] OFFS_DATA   = 5'h10;
    localparam logic [OFFS_W-1:0] OFFS_INDEX  = 5'h12;
    localparam logic [OFFS_W-1:0] OFFS_RESET  = 5'h14;
    localparam logic [OFFS_W-1:0] OFFS_BUSCFG = 5'h16;

    // Register numbers
    localparam int unsigned REG_CTL   = 0;
    localparam int unsigned REG_IBLO  = 1;
    localparam int unsigned REG_IBHI  = 2;
    localparam int unsigned REG_FEAT  = 4;
    localparam int unsigned REG_IDLO  = 88;
    localparam int unsigned REG_IDHI  = 89;
    localparam int unsigned BUS_MEDIA = 2;

    // Bit positions in the command/status word
    localparam int BIT_INIT  = 0;
    localparam int BIT_START = 1;
    localparam int BIT_STOP  = 2;
    localparam int BIT_TDMD  = 3;
    localparam int FLAG_LSB  = 8;   // init done, tx, rx flags follow upward

    localparam int BUS_AUTOSEL_BIT = 1;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_CSR,
        RD_INDEX,
        RD_RESET,
        RD_BUS
    } rd_src_e;

    typedef struct packed {
        logic               init;
        logic               start;
        logic               stop;
        logic               tdmd;
        logic [NUM_EVT-1:0] clr;
    } ctl_cmd_t;

    typedef struct packed {
        logic [NUM_EVT-1:0] flag;
        logic               stop;
        logic               start;
        logic               init;
    } ctl_state_t;

    typedef struct packed {
        logic              soft_rst;
        logic              ctl_wr;
        ctl_cmd_t          cmd;
        logic              iblo_wr;
        logic              ibhi_wr;
        logic              feat_wr;
        logic              media_wr;
        logic [WORD_W-1:0] wdata;
    } wr_req_t;

    function automatic logic [WORD_W-1:0] ctl_word(ctl_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_INIT]  = s.init;
        w[BIT_START] = s.start;
        w[BIT_STOP]  = s.stop;
        w[FLAG_LSB +: NUM_EVT] = s.flag;
        return w;
    endfunction

    function automatic logic [2*WORD_W-1:0] chip_id(logic [WORD_W-1:0] part);
        return {4'h0, part, 12'h003};
    endfunction

endpackage

// File: rtl/ics_port_decode.sv
module ics_port_decode
    import ics_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [OFFS_W-1:0]    bus_offs,
    input  logic [WORD_W-1:0]    bus_wdata,
    output wr_req_t              req,
    output rd_src_e              rd_src,
    output logic [IDX_W-1:0]     idx,
    output logic                 ctl_rst
);

    logic [IDX_W-1:0] idx_q;
    logic             soft_rst;
    logic             data_wr;
    logic             bus_cfg_wr;
    logic             index_wr;
    logic             ctl_rst_q;

    assign soft_rst   = bus_rd && (bus_offs == OFFS_RESET);
    assign data_wr    = bus_wr && (bus_offs == OFFS_DATA);
    assign bus_cfg_wr = bus_wr && (bus_offs == OFFS_BUSCFG);
    assign index_wr   = bus_wr && (bus_offs == OFFS_INDEX);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            idx_q <= '0;
        end else if (index_wr) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_rst_q <= 1'b0;
        end else begin
            ctl_rst_q <= soft_rst;
        end
    end

    always_comb begin
        req           = '0;
        req.soft_rst  = soft_rst;
        req.wdata     = bus_wdata;
        req.ctl_wr    = data_wr && (idx_q == IDX_W'(REG_CTL));
        req.iblo_wr   = data_wr && (idx_q == IDX_W'(REG_IBLO));
        req.ibhi_wr   = data_wr && (idx_q == IDX_W'(REG_IBHI));
        req.feat_wr   = data_wr && (idx_q == IDX_W'(REG_FEAT));
        req.media_wr  = bus_cfg_wr && (idx_q == IDX_W'(BUS_MEDIA));
        req.cmd.init  = bus_wdata[BIT_INIT];
        req.cmd.start = bus_wdata[BIT_START];
        req.cmd.stop  = bus_wdata[BIT_STOP];
        req.cmd.tdmd  = bus_wdata[BIT_TDMD];
        req.cmd.clr   = bus_wdata[FLAG_LSB +: NUM_EVT];
    end

    always_comb begin
        rd_src = RD_NONE;
        if (bus_rd) begin
            case (bus_offs)
                OFFS_DATA:   rd_src = RD_CSR;
                OFFS_INDEX:  rd_src = RD_INDEX;
                OFFS_RESET:  rd_src = RD_RESET;
                OFFS_BUSCFG: rd_src = RD_BUS;
                default:     rd_src = RD_NONE;
            endcase
        end
    end

    assign idx     = idx_q;
    assign ctl_rst = ctl_rst_q;

    // R2
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (index_wr && !soft_rst) |=> (idx_q == $past(bus_wdata[IDX_W-1:0])));

    // R12
    index_soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (idx_q == '0) && ctl_rst);

endmodule

// File: rtl/ics_ctl_reg.sv
module ics_ctl_reg
    import ics_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               ctl_wr,
    input  ctl_cmd_t           cmd,
    input  logic [NUM_EVT-1:0] evt,
    output ctl_state_t         st,
    output logic               init_go,
    output logic               start_go,
    output logic               stop_go,
    output logic               tx_demand
);

    logic               init_q;
    logic               start_q;
    logic               stop_q;
    logic [NUM_EVT-1:0] flag_q;
    logic               clr_all;
    logic               do_stop;
    logic               do_init;
    logic               do_start;
    logic               do_tdmd;

    assign clr_all  = rst || soft_rst;
    assign do_stop  = ctl_wr && cmd.stop;
    assign do_init  = ctl_wr && cmd.init  && !cmd.stop;
    assign do_start = ctl_wr && cmd.start && !cmd.stop;
    assign do_tdmd  = ctl_wr && cmd.tdmd  && !cmd.stop;

    // Run state: stop has priority, ones set, zeros do nothing
    always_ff @(posedge clk) begin
        if (clr_all || do_stop) begin
            init_q  <= 1'b0;
            start_q <= 1'b0;
            stop_q  <= 1'b1;
        end else begin
            if (do_init) begin
                init_q <= 1'b1;
                stop_q <= 1'b0;
            end
            if (do_start) begin
                start_q <= 1'b1;
                stop_q  <= 1'b0;
            end
        end
    end

    // Sticky event flags: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (clr_all) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < NUM_EVT; i++) begin
                if (evt[i] && !stop_q) begin
                    flag_q[i] <= 1'b1;
                end else if (ctl_wr && cmd.clr[i]) begin
                    flag_q[i] <= 1'b0;
                end
            end
        end
    end

    // Command strobes, one cycle after the write
    always_ff @(posedge clk) begin
        if (clr_all) begin
            init_go   <= 1'b0;
            start_go  <= 1'b0;
            stop_go   <= 1'b0;
            tx_demand <= 1'b0;
        end else begin
            init_go   <= do_init;
            start_go  <= do_start;
            stop_go   <= do_stop;
            tx_demand <= do_tdmd;
        end
    end

    assign st = {flag_q, stop_q, start_q, init_q};

    // R9
    stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && cmd.stop && !soft_rst) |=> (stop_q && !start_q && !init_q));

    // R9
    stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        stop_go |-> !(init_go || start_go || tx_demand));

    // R7
    tdmd_origin_chk: assert property (@(posedge clk) disable iff (rst)
        tx_demand |-> $past(ctl_wr && cmd.tdmd));

    // R12
    ctl_soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (st == ctl_state_t'({{NUM_EVT{1'b0}}, 3'b100})));

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag_chk
        // R5, R8
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            (evt[g] && !stop_q && !soft_rst) |=> flag_q[g]);
        // R8
        flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl_wr && cmd.clr[g] && !evt[g]) |=> !flag_q[g]);
    end

endmodule

// File: rtl/ics_cfg_regs.sv
module ics_cfg_regs
    import ics_pkg::*;
#(
    parameter logic [WORD_W-1:0] FEAT_RST   = '0,
    parameter logic [WORD_W-1:0] BUSCFG_RST = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              iblo_wr,
    input  logic              ibhi_wr,
    input  logic              feat_wr,
    input  logic              media_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ib_lo,
    output logic [WORD_W-1:0] ib_hi,
    output logic [WORD_W-1:0] feat,
    output logic [WORD_W-1:0] media
);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ib_lo <= '0;
            ib_hi <= '0;
            feat  <= FEAT_RST;
            media <= BUSCFG_RST;
        end else begin
            if (iblo_wr)  ib_lo <= wdata;
            if (ibhi_wr)  ib_hi <= wdata;
            if (feat_wr)  feat  <= wdata;
            if (media_wr) media <= wdata;
        end
    end

    // R10
    feat_write_chk: assert property (@(posedge clk) disable iff (rst)
        (feat_wr && !soft_rst) |=> (feat == $past(wdata)));

    // R11
    media_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!media_wr && !soft_rst) |=> $stable(media));

endmodule

// File: rtl/ics_read_mux.sv
module ics_read_mux
    import ics_pkg::*;
#(
    parameter int                IDX_W   = 7,
    parameter logic [WORD_W-1:0] PART_ID = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_src_e           rd_src,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] ctl_w,
    input  logic [WORD_W-1:0] ib_lo,
    input  logic [WORD_W-1:0] ib_hi,
    input  logic [WORD_W-1:0] feat,
    input  logic [WORD_W-1:0] media,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    localparam logic [2*WORD_W-1:0] ID_WORD = chip_id(PART_ID);

    logic [WORD_W-1:0] csr_val;
    logic [WORD_W-1:0] mux_val;

    always_comb begin
        csr_val = '0;
        if (idx == IDX_W'(REG_CTL))       csr_val = ctl_w;
        else if (idx == IDX_W'(REG_IBLO)) csr_val = ib_lo;
        else if (idx == IDX_W'(REG_IBHI)) csr_val = ib_hi;
        else if (idx == IDX_W'(REG_FEAT)) csr_val = feat;
        else if (idx == IDX_W'(REG_IDLO)) csr_val = ID_WORD[WORD_W-1:0];
        else if (idx == IDX_W'(REG_IDHI)) csr_val = ID_WORD[2*WORD_W-1:WORD_W];
    end

    always_comb begin
        case (rd_src)
            RD_CSR:   mux_val = csr_val;
            RD_INDEX: mux_val = {{(WORD_W-IDX_W){1'b0}}, idx};
            RD_BUS:   mux_val = (idx == IDX_W'(BUS_MEDIA)) ? media : '0;
            default:  mux_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= (rd_src != RD_NONE);
            rdata  <= mux_val;
        end
    end

    // R12
    reset_port_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_src == RD_RESET) |=> (rvalid && rdata == '0));

endmodule

// File: rtl/ind_csr_ctrl.sv
module ind_csr_ctrl
    import ics_pkg::*;
#(
    parameter int                IDX_W      = 7,
    parameter logic [WORD_W-1:0] PART_ID    = 16'h5A3C,
    parameter logic [WORD_W-1:0] FEAT_RST   = '0,
    parameter logic [WORD_W-1:0] BUSCFG_RST = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [OFFS_W-1:0]   bus_offs,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic                ctl_rst,
    output logic                init_go,
    output logic [2*WORD_W-1:0] init_addr,
    output logic                start_go,
    output logic                stop_go,
    output logic                tx_demand,
    input  logic                init_loaded,
    input  logic                tx_event,
    input  logic                rx_event,
    output logic [WORD_W-1:0]   feature_word,
    output logic [WORD_W-1:0]   bus_cfg_word,
    output logic                media_autosel
);

    wr_req_t           req;
    rd_src_e           rd_src;
    logic [IDX_W-1:0]  idx;
    ctl_state_t        ctl_st;
    logic [WORD_W-1:0] ctl_w;
    logic [WORD_W-1:0] ib_lo;
    logic [WORD_W-1:0] ib_hi;
    logic [WORD_W-1:0] feat;
    logic [WORD_W-1:0] media;

    ics_port_decode #(.IDX_W(IDX_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_offs  (bus_offs),
        .bus_wdata (bus_wdata),
        .req       (req),
        .rd_src    (rd_src),
        .idx       (idx),
        .ctl_rst   (ctl_rst)
    );

    ics_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (req.soft_rst),
        .ctl_wr    (req.ctl_wr),
        .cmd       (req.cmd),
        .evt       ({rx_event, tx_event, init_loaded}),
        .st        (ctl_st),
        .init_go   (init_go),
        .start_go  (start_go),
        .stop_go   (stop_go),
        .tx_demand (tx_demand)
    );

    ics_cfg_regs #(
        .FEAT_RST   (FEAT_RST),
        .BUSCFG_RST (BUSCFG_RST)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (req.soft_rst),
        .iblo_wr   (req.iblo_wr),
        .ibhi_wr   (req.ibhi_wr),
        .feat_wr   (req.feat_wr),
        .media_wr  (req.media_wr),
        .wdata     (req.wdata),
        .ib_lo     (ib_lo),
        .ib_hi     (ib_hi),
        .feat      (feat),
        .media     (media)
    );

    assign ctl_w = ctl_word(ctl_st);

    ics_read_mux #(
        .IDX_W   (IDX_W),
        .PART_ID (PART_ID)
    ) u_rmux (
        .clk    (clk),
        .rst    (rst),
        .rd_src (rd_src),
        .idx    (idx),
        .ctl_w  (ctl_w),
        .ib_lo  (ib_lo),
        .ib_hi  (ib_hi),
        .feat   (feat),
        .media  (media),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

    assign init_addr     = {ib_hi, ib_lo};
    assign feature_word  = feat;
    assign bus_cfg_word  = media;
    assign media_autosel = media[BUS_AUTOSEL_BIT];

    // R4
    init_addr_chk: assert property (@(posedge clk) disable iff (rst)
        init_go |-> $stable(init_addr));

endmodule

// File: tb/ind_csr_ctrl_tb.sv
module ind_csr_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_offs = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        ctl_rst;
    logic        init_go;
    logic [31:0] init_addr;
    logic        start_go;
    logic        stop_go;
    logic        tx_demand;
    logic        init_loaded = 1'b0;
    logic        tx_event = 1'b0;
    logic        rx_event = 1'b0;
    logic [15:0] feature_word;
    logic [15:0] bus_cfg_word;
    logic        media_autosel;

    int n_checks = 0;
    int n_errs   = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_csr_ctrl u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_offs      (bus_offs),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_rvalid    (bus_rvalid),
        .ctl_rst       (ctl_rst),
        .init_go       (init_go),
        .init_addr     (init_addr),
        .start_go      (start_go),
        .stop_go       (stop_go),
        .tx_demand     (tx_demand),
        .init_loaded   (init_loaded),
        .tx_event      (tx_event),
        .rx_event      (rx_event),
        .feature_word  (feature_word),
        .bus_cfg_word  (bus_cfg_word),
        .media_autosel (media_autosel)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io_write(logic [4:0] offs, logic [15:0] data);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_offs  = offs;
        bus_wdata = data;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic io_read(logic [4:0] offs, logic [15:0] exp, string tag);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_offs = offs;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic csr_wr(logic [15:0] idx, logic [15:0] data);
        io_write(5'h12, idx);
        io_write(5'h10, data);
    endtask

    task automatic csr_rd(logic [15:0] idx, logic [15:0] exp, string tag);
        io_write(5'h12, idx);
        io_read(5'h10, exp, tag);
    endtask

    task automatic strobes(string tag, logic [3:0] exp);
        chk(tag, {28'h0, init_go, start_go, stop_go, tx_demand}, {28'h0, exp});
    endtask

    // Scoreboard monitor: one expected word per read answer
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected read answer", 32'h1, 32'h0);
            end else begin
                chk(tag_q.pop_front(), {16'h0, bus_rdata}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        chk("watchdog expired", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        strobes("R1 strobes after reset", 4'b0000);
        chk("R1 ctl_rst after reset", {31'h0, ctl_rst}, 32'h0);
        io_read(5'h12, 16'h0000, "R13 R1 index after reset");
        io_read(5'h10, 16'h0004, "R1 reg0 after reset");
        csr_rd(16'd4, 16'h0000, "R1 reg4 after reset");
        chk("R1 bus cfg after reset", {16'h0, bus_cfg_word}, 32'h0);

        // R2 index readback
        io_write(5'h12, 16'd88);
        io_read(5'h12, 16'd88, "R2 index readback 88");
        io_write(5'h12, 16'hFF05);
        io_read(5'h12, 16'h0005, "R2 index truncated");

        // R3 chip identifier
        csr_rd(16'd88, 16'hC003, "R3 id low");
        csr_rd(16'd89, 16'h05A3, "R3 id high");
        io_write(5'h10, 16'hFFFF);
        io_read(5'h10, 16'h05A3, "R3 id write ignored");

        // R4 init-block address and init command
        csr_wr(16'd1, 16'h5678);
        strobes("R4 no strobe on reg1 write", 4'b0000);
        csr_wr(16'd2, 16'h1234);
        csr_rd(16'd1, 16'h5678, "R4 reg1 readback");
        csr_rd(16'd2, 16'h1234, "R4 reg2 readback");
        csr_wr(16'd0, 16'h0001);
        strobes("R4 init strobe", 4'b1000);
        chk("R4 init_addr", init_addr, 32'h12345678);
        @(negedge clk);
        strobes("R4 init strobe one cycle", 4'b0000);
        io_read(5'h10, 16'h0001, "R4 reg0 after init");

        // R5 init done
        @(negedge clk); init_loaded = 1'b1;
        @(negedge clk); init_loaded = 1'b0;
        io_read(5'h10, 16'h0101, "R5 init done set");

        // R6 start and zero writes
        io_write(5'h10, 16'h0002);
        strobes("R6 start strobe", 4'b0100);
        io_read(5'h10, 16'h0103, "R6 reg0 after start");
        io_write(5'h10, 16'h0000);
        strobes("R6 zero write no strobe", 4'b0000);
        io_read(5'h10, 16'h0103, "R6 zero write no effect");

        // R7 transmit demand
        io_write(5'h10, 16'h0008);
        strobes("R7 tx demand strobe", 4'b0001);
        @(negedge clk);
        strobes("R7 tx demand self clear", 4'b0000);
        io_read(5'h10, 16'h0103, "R7 bit3 reads zero");

        // R8 event flags and write-one-to-clear
        @(negedge clk); tx_event = 1'b1;
        @(negedge clk); tx_event = 1'b0; rx_event = 1'b1;
        @(negedge clk); rx_event = 1'b0;
        io_read(5'h10, 16'h0703, "R8 tx and rx flags set");
        io_write(5'h10, 16'h0500);
        io_read(5'h10, 16'h0203, "R8 clear rx and init done");
        io_write(5'h10, 16'h0200);
        io_read(5'h10, 16'h0003, "R8 clear tx");
        @(negedge clk);
        bus_wr = 1'b1; bus_offs = 5'h10; bus_wdata = 16'h0400; rx_event = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_event = 1'b0;
        io_read(5'h10, 16'h0403, "R8 set wins over clear");
        io_write(5'h10, 16'h0400);
        io_read(5'h10, 16'h0003, "R8 clear after collision");

        // R9 stop priority and idle
        io_write(5'h10, 16'h000B | 16'h0004);
        strobes("R9 only stop strobe", 4'b0010);
        io_read(5'h10, 16'h0004, "R9 reg0 stopped");
        @(negedge clk); rx_event = 1'b1; tx_event = 1'b1;
        @(negedge clk); rx_event = 1'b0; tx_event = 1'b0;
        io_read(5'h10, 16'h0004, "R9 events ignored when stopped");

        // R10 feature word
        csr_wr(16'd4, 16'h0915);
        chk("R10 feature_word", {16'h0, feature_word}, 32'h0915);
        io_read(5'h10, 16'h0915, "R10 reg4 readback");

        // R11 bus configuration bank
        io_write(5'h12, 16'd2);
        io_write(5'h16, 16'h0002);
        chk("R11 media_autosel", {31'h0, media_autosel}, 32'h1);
        chk("R11 bus_cfg_word", {16'h0, bus_cfg_word}, 32'h0002);
        io_read(5'h16, 16'h0002, "R11 bus cfg readback");
        io_read(5'h10, 16'h1234, "R11 data reg2 separate");
        io_write(5'h12, 16'd3);
        io_read(5'h16, 16'h0000, "R11 other index reads zero");

        // R12 reset port
        csr_wr(16'd0, 16'h0003);
        io_read(5'h10, 16'h0003, "R12 setup running");
        io_read(5'h14, 16'h0000, "R12 reset port data");
        chk("R12 ctl_rst pulse", {31'h0, ctl_rst}, 32'h1);
        @(negedge clk);
        chk("R12 ctl_rst one cycle", {31'h0, ctl_rst}, 32'h0);
        io_read(5'h12, 16'h0000, "R12 index cleared");
        io_read(5'h10, 16'h0004, "R12 reg0 stopped");
        csr_rd(16'd4, 16'h0000, "R12 reg4 cleared");
        chk("R12 init_addr cleared", init_addr, 32'h0);
        chk("R12 media_autosel cleared", {31'h0, media_autosel}, 32'h0);

        repeat (3) @(negedge clk);
        chk("R13 all reads answered", exp_q.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule